// File: doc/BRIEF.md
# Capture-Mode Timer Channel

This block is one 16-bit counter channel that timestamps edges on a capture input. The counting clock is chosen from eight sources: five prescaled internal clock levels and three external clock inputs. It may advance on the rising or the falling edge of that source, and it may be qualified by one of the external inputs used as a gate. When the chosen edge is seen on the capture input, the current count is copied into capture slot A or capture slot B. The two slots load in strict alternation.

All inputs are sampled by the single system clock. The "counting clock" is a one-cycle advance pulse, produced when an edge is detected on the selected, gated source. A mode word sets up the channel. Separate strobes enable or disable counting, issue a software trigger, acknowledge each capture slot and clear the sticky status flags.

Loading slot B can pause counting until the next trigger, or switch counting off until software enables it again. A trigger, from software or from a match against a compare value, rearms slot A. It also makes the next advance pulse return the counter to zero.

Top module: `capt_timer_top`

## Requirements
- R1: Mode bits [2:0] pick the counting source: codes 0..4 select internal clocks 0..4, and codes 5, 6 and 7 select external clocks 0, 1 and 2. While counting is running, each selected edge advances the counter by one at the next system clock edge. Edges on sources that are not selected have no effect.
- R2: Mode bit 3 at 0 counts rising edges of the source. At 1 it counts falling edges, and rising edges are then ignored.
- R3: Mode bits [5:4] set the gate: 0 means ungated, and codes 1, 2 and 3 AND the source with external clock 0, 1 or 2 before edge detection. A source edge that occurs while the gate is low does not count.
- R4: After reset the counter, both slots, both valid bits and both flags are 0, and counting is off. `enStrobe` turns counting on and `disStrobe` turns it off; if both come in the same cycle, counting is off. While counting is off, source edges are ignored.
- R5: A software trigger makes the next advance pulse load 0 instead of incrementing. This also applies when the counter holds 0xFFFF, and in that case the overflow flag is not set.
- R6: With mode bit 12 set, an advance pulse that arrives while the counter equals `rcValue` loads 0. With bit 12 clear, the counter counts past that value.
- R7: An advance pulse at 0xFFFF with no trigger pending wraps the counter to 0 and sets `ovflFlag`. `statusRd` clears the flag.
- R8: Mode bits [9:8] (slot A) and [11:10] (slot B) select the capture edge: 0 none, 1 rising, 2 falling, 3 either. A load copies the count that holds in the cycle the input edge is sampled, and it sets the slot's valid bit. `rdA` or `rdB` clears that valid bit.
- R9: Slot B loads only after slot A has loaded, and slot A loads again only after slot B. Reset and every trigger rearm slot A and disarm slot B.
- R10: With mode bit 6 set, a slot B load stops counting. The next software trigger restarts it, and the first advance pulse after that loads 0.
- R11: With mode bit 7 set, a slot B load turns counting off. A trigger alone does not restart it; `enStrobe` is required.
- R12: A load into a slot whose valid bit is still set (and not being cleared by a read in the same cycle) sets `lovrFlag`. `statusRd` clears the flag.
- R13: Mode bit 13 selects a mode this block does not provide. While it is set, the channel neither counts nor captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeWord | input | 14 | Channel configuration word |
| rcValue | input | 16 | Compare value used for compare triggering |
| intClk | input | 5 | Prescaled internal clock levels |
| extClk | input | 3 | External clock levels, also usable as gates |
| capIn | input | 1 | Capture input |
| enStrobe | input | 1 | Turn counting on |
| disStrobe | input | 1 | Turn counting off |
| swTrig | input | 1 | Software trigger |
| rdA | input | 1 | Acknowledge slot A |
| rdB | input | 1 | Acknowledge slot B |
| statusRd | input | 1 | Clear overflow and overrun flags |
| count | output | 16 | Counter value |
| capA | output | 16 | Capture slot A |
| capB | output | 16 | Capture slot B |
| capAValid | output | 1 | Slot A holds an unread value |
| capBValid | output | 1 | Slot B holds an unread value |
| ovflFlag | output | 1 | Counter wrapped |
| lovrFlag | output | 1 | A capture slot was overwritten unread |
| running | output | 1 | Counting currently allowed |

## Verification
Every result is due exactly one system clock after its cause is sampled. A source or capture-input edge updates the counter, slot, valid bit or flag at the next rising clock edge. A strobe changes `running` or a flag at that same edge. A trigger shows up only at the first advance pulse after it. The bench changes every input on the falling clock edge and reads outputs at the following falling edge. Each task therefore sees its effect after exactly one rising edge. The counter is taken to 0xFFFF by toggling the source and the edge-polarity bit together, which gives one advance per cycle.

// File: rtl/capt_pkg.sv
package capt_pkg;

  localparam int CNT_W  = 16;
  localparam int N_INT  = 5;
  localparam int N_EXT  = 3;
  localparam int SEL_W  = 3;
  localparam int GATE_W = 2;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_mode_e;

  // bit 13 down to bit 0
  typedef struct packed {
    logic              waveSel;
    logic              rcTrigEn;
    edge_mode_e        edgeB;
    edge_mode_e        edgeA;
    logic              disOnB;
    logic              stopOnB;
    logic [GATE_W-1:0] gateSel;
    logic              clkInv;
    logic [SEL_W-1:0]  clkSel;
  } capt_mode_t;

  localparam int MODE_W = $bits(capt_mode_t);

  // strobes from control to datapath
  typedef struct packed {
    logic cntInc;
    logic cntClear;
    logic loadA;
    logic loadB;
  } capt_strobe_t;

endpackage

// File: rtl/capt_clk_src.sv
module capt_clk_src
  import capt_pkg::*;
#(
  parameter int NI = N_INT,
  parameter int NE = N_EXT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NI-1:0]     intClk,
  input  logic [NE-1:0]     extClk,
  input  logic [SEL_W-1:0]  clkSel,
  input  logic              clkInv,
  input  logic [GATE_W-1:0] gateSel,
  output logic              srcEdge
);

  localparam int N_SRC = NI + NE;

  logic [N_SRC-1:0] srcVec;
  logic [NE:0]      gateVec;
  logic             selLvl;
  logic             gateLvl;
  logic             gatedLvl;
  logic             gatedPrev;

  assign srcVec  = {extClk, intClk};
  assign gateVec = {extClk, 1'b1};

  always_comb begin
    selLvl = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (clkSel == SEL_W'(i)) selLvl = srcVec[i];
    end
  end

  always_comb begin
    gateLvl = 1'b0;
    for (int i = 0; i <= NE; i++) begin
      if (gateSel == GATE_W'(i)) gateLvl = gateVec[i];
    end
  end

  assign gatedLvl = selLvl & gateLvl;

  always_ff @(posedge clk) begin
    if (!rstN) gatedPrev <= 1'b0;
    else       gatedPrev <= gatedLvl;
  end

  assign srcEdge = clkInv ? (gatedPrev & ~gatedLvl) : (~gatedPrev & gatedLvl);

  // a closed gate yields no advance edge, whatever the source does
  p_gate_closed_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!gateLvl && !gatedPrev) |-> !srcEdge);

endmodule

// File: rtl/capt_ctrl.sv
module capt_ctrl
  import capt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         waveSel,
  input  logic         rcTrigEn,
  input  logic         stopOnB,
  input  logic         disOnB,
  input  edge_mode_e   edgeA,
  input  edge_mode_e   edgeB,
  input  logic         srcEdge,
  input  logic         capIn,
  input  logic         enStrobe,
  input  logic         disStrobe,
  input  logic         swTrig,
  input  logic         rcMatch,
  output capt_strobe_t st,
  output logic         running
);

  logic enabled;
  logic stopped;
  logic trigPend;
  logic armA;
  logic armB;
  logic capPrev;
  logic capRise;
  logic capFall;
  logic tick;
  logic rcHit;
  logic trigEvent;

  function automatic logic edgeHit(edge_mode_e m, logic r, logic f);
    case (m)
      EDGE_RISE: return r;
      EDGE_FALL: return f;
      EDGE_BOTH: return r | f;
      default:   return 1'b0;
    endcase
  endfunction

  assign capRise = capIn & ~capPrev;
  assign capFall = ~capIn & capPrev;

  assign running   = enabled & ~stopped & ~waveSel;
  assign tick      = srcEdge & running;
  assign rcHit     = rcTrigEn & rcMatch;
  assign trigEvent = swTrig | (tick & rcHit);

  always_comb begin
    st          = '0;
    st.cntClear = tick & (trigPend | rcHit);
    st.cntInc   = tick & ~(trigPend | rcHit);
    st.loadA    = ~waveSel & armA & edgeHit(edgeA, capRise, capFall);
    st.loadB    = ~waveSel & armB & edgeHit(edgeB, capRise, capFall);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capPrev  <= 1'b0;
      enabled  <= 1'b0;
      stopped  <= 1'b0;
      trigPend <= 1'b0;
      armA     <= 1'b1;
      armB     <= 1'b0;
    end else begin
      capPrev <= capIn;

      if (disStrobe || (st.loadB && disOnB)) enabled <= 1'b0;
      else if (enStrobe)                     enabled <= 1'b1;

      if (st.loadB && stopOnB) stopped <= 1'b0 | 1'b1;
      else if (swTrig)         stopped <= 1'b0;

      if (swTrig)    trigPend <= 1'b1;
      else if (tick) trigPend <= 1'b0;

      if (trigEvent) begin
        armA <= 1'b1;
        armB <= 1'b0;
      end else if (st.loadA) begin
        armA <= 1'b0;
        armB <= 1'b1;
      end else if (st.loadB) begin
        armA <= 1'b1;
        armB <= 1'b0;
      end
    end
  end

  p_one_slot_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(st.loadA && st.loadB));

  p_stop_on_b_r10: assert property (@(posedge clk) disable iff (!rstN)
    (st.loadB && stopOnB && !waveSel) |=> !running);

  p_off_on_b_r11: assert property (@(posedge clk) disable iff (!rstN)
    (st.loadB && disOnB) |=> !enabled);

  p_wave_idle_r13: assert property (@(posedge clk) disable iff (!rstN)
    waveSel |-> !(st.cntInc || st.cntClear || st.loadA || st.loadB));

endmodule

// File: rtl/capt_datapath.sv
module capt_datapath
  import capt_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  capt_strobe_t st,
  input  logic [W-1:0] rcValue,
  input  logic         rdA,
  input  logic         rdB,
  input  logic         statusRd,
  output logic [W-1:0] count,
  output logic [W-1:0] capA,
  output logic [W-1:0] capB,
  output logic         capAValid,
  output logic         capBValid,
  output logic         ovflFlag,
  output logic         lovrFlag,
  output logic         rcMatch
);

  localparam int          N_SLOT  = 2;
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [N_SLOT-1:0] loadVec;
  logic [N_SLOT-1:0] rdVec;
  logic [N_SLOT-1:0] ovrVec;
  logic              wrapEvt;

  assign loadVec = {st.loadB, st.loadA};
  assign rdVec   = {rdB, rdA};
  assign wrapEvt = st.cntInc && (count == CNT_MAX);
  assign rcMatch = (count == rcValue);

  always_ff @(posedge clk) begin
    if (!rstN)            count <= '0;
    else if (st.cntClear) count <= '0;
    else if (st.cntInc)   count <= count + W'(1);
  end

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    logic [W-1:0] capQ;
    logic         validQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        capQ   <= '0;
        validQ <= 1'b0;
      end else if (loadVec[g]) begin
        capQ   <= count;
        validQ <= 1'b1;
      end else if (rdVec[g]) begin
        validQ <= 1'b0;
      end
    end

    assign ovrVec[g] = loadVec[g] & validQ & ~rdVec[g];
  end

  assign capA      = g_slot[0].capQ;
  assign capB      = g_slot[1].capQ;
  assign capAValid = g_slot[0].validQ;
  assign capBValid = g_slot[1].validQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovflFlag <= 1'b0;
      lovrFlag <= 1'b0;
    end else begin
      if (wrapEvt)       ovflFlag <= 1'b1;
      else if (statusRd) ovflFlag <= 1'b0;
      if (|ovrVec)       lovrFlag <= 1'b1;
      else if (statusRd) lovrFlag <= 1'b0;
    end
  end

  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    st.cntClear |=> (count == '0));

  p_wrap_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    (st.cntInc && count == CNT_MAX) |=> (count == '0 && ovflFlag));

  p_cap_value_r8: assert property (@(posedge clk) disable iff (!rstN)
    st.loadA |=> (capA == $past(count) && capAValid));

  p_overrun_r12: assert property (@(posedge clk) disable iff (!rstN)
    (st.loadA && capAValid && !rdA) |=> lovrFlag);

endmodule

// File: rtl/capt_timer_top.sv
module capt_timer_top
  import capt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [MODE_W-1:0]    modeWord,
  input  logic [CNT_W-1:0]     rcValue,
  input  logic [N_INT-1:0]     intClk,
  input  logic [N_EXT-1:0]     extClk,
  input  logic                 capIn,
  input  logic                 enStrobe,
  input  logic                 disStrobe,
  input  logic                 swTrig,
  input  logic                 rdA,
  input  logic                 rdB,
  input  logic                 statusRd,
  output logic [CNT_W-1:0]     count,
  output logic [CNT_W-1:0]     capA,
  output logic [CNT_W-1:0]     capB,
  output logic                 capAValid,
  output logic                 capBValid,
  output logic                 ovflFlag,
  output logic                 lovrFlag,
  output logic                 running
);

  capt_mode_t   modeS;
  capt_strobe_t strobes;
  logic         srcEdge;
  logic         rcMatch;

  assign modeS = modeWord;

  capt_clk_src #(.NI(N_INT), .NE(N_EXT)) clk_src_i (
    .clk     (clk),
    .rstN    (rstN),
    .intClk  (intClk),
    .extClk  (extClk),
    .clkSel  (modeS.clkSel),
    .clkInv  (modeS.clkInv),
    .gateSel (modeS.gateSel),
    .srcEdge (srcEdge)
  );

  capt_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .waveSel   (modeS.waveSel),
    .rcTrigEn  (modeS.rcTrigEn),
    .stopOnB   (modeS.stopOnB),
    .disOnB    (modeS.disOnB),
    .edgeA     (modeS.edgeA),
    .edgeB     (modeS.edgeB),
    .srcEdge   (srcEdge),
    .capIn     (capIn),
    .enStrobe  (enStrobe),
    .disStrobe (disStrobe),
    .swTrig    (swTrig),
    .rcMatch   (rcMatch),
    .st        (strobes),
    .running   (running)
  );

  capt_datapath #(.W(CNT_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .st        (strobes),
    .rcValue   (rcValue),
    .rdA       (rdA),
    .rdB       (rdB),
    .statusRd  (statusRd),
    .count     (count),
    .capA      (capA),
    .capB      (capB),
    .capAValid (capAValid),
    .capBValid (capBValid),
    .ovflFlag  (ovflFlag),
    .lovrFlag  (lovrFlag),
    .rcMatch   (rcMatch)
  );

endmodule

// File: tb/capt_timer_tb.sv
module capt_timer_top_tb_top;
  import capt_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 190000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  capt_mode_t  modeR = '0;
  logic [15:0] rcValue = '0;
  logic [7:0]  srcs = '0;
  logic        capIn = 1'b0;
  logic        enStrobe = 1'b0, disStrobe = 1'b0, swTrig = 1'b0;
  logic        rdA = 1'b0, rdB = 1'b0, statusRd = 1'b0;
  logic [15:0] count, capA, capB;
  logic        capAValid, capBValid, ovflFlag, lovrFlag, running;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  capt_timer_top dut_i (
    .clk(clk), .rstN(rstN), .modeWord(modeR), .rcValue(rcValue),
    .intClk(srcs[4:0]), .extClk(srcs[7:5]), .capIn(capIn),
    .enStrobe(enStrobe), .disStrobe(disStrobe), .swTrig(swTrig),
    .rdA(rdA), .rdB(rdB), .statusRd(statusRd),
    .count(count), .capA(capA), .capB(capB),
    .capAValid(capAValid), .capBValid(capBValid),
    .ovflFlag(ovflFlag), .lovrFlag(lovrFlag), .running(running)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic srcPulse(input int idx);
    @(negedge clk) srcs[idx] = 1'b1;
    @(negedge clk) srcs[idx] = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulses(input int idx, input int n);
    for (int k = 0; k < n; k++) srcPulse(idx);
  endtask

  task automatic capSet(input logic v);
    @(negedge clk) capIn = v;
    @(negedge clk);
  endtask

  task automatic doEn();
    @(negedge clk) enStrobe = 1'b1;
    @(negedge clk) enStrobe = 1'b0;
  endtask

  task automatic doDis();
    @(negedge clk) disStrobe = 1'b1;
    @(negedge clk) disStrobe = 1'b0;
  endtask

  task automatic doTrig();
    @(negedge clk) swTrig = 1'b1;
    @(negedge clk) swTrig = 1'b0;
  endtask

  task automatic doRead(input logic a, input logic b, input logic s);
    @(negedge clk) begin rdA = a; rdB = b; statusRd = s; end
    @(negedge clk) begin rdA = 1'b0; rdB = 1'b0; statusRd = 1'b0; end
  endtask

  task automatic baseMode();
    @(negedge clk) modeR = '0;
  endtask

  // one advance per cycle: flip the source and the edge polarity together
  task automatic fastCount(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      srcs[0] = ~srcs[0];
      modeR.clkInv = ~srcs[0];
    end
    @(negedge clk) modeR.clkInv = 1'b0;
  endtask

  task automatic testReset();
    chk("R4 reset count", count, 0);
    chk("R4 reset running", running, 0);
    chk("R4 reset valid", {capAValid, capBValid}, 0);
    chk("R4 reset flags", {ovflFlag, lovrFlag}, 0);
    chk("R4 reset slots", {capA, capB}, 0);
  endtask

  task automatic testEnable();
    baseMode();
    srcPulse(0);
    chk("R4 edge ignored while off", count, 0);
    doEn();
    chk("R4 running after enable", running, 1);
    pulses(0, 3);
    chk("R1 three advances", count, 3);
    doDis();
    srcPulse(0);
    chk("R4 no advance after disable", count, 3);
    @(negedge clk) begin enStrobe = 1'b1; disStrobe = 1'b1; end
    @(negedge clk) begin enStrobe = 1'b0; disStrobe = 1'b0; end
    chk("R4 disable wins", running, 0);
    doEn();
  endtask

  task automatic testSelect();
    for (int c = 0; c < 8; c++) begin
      @(negedge clk) modeR.clkSel = 3'(c);
      doTrig();
      srcPulse(c);
      chk($sformatf("R1 code %0d trigger clear", c), count, 0);
      pulses(c, 2);
      chk($sformatf("R1 code %0d counts", c), count, 2);
      srcPulse((c + 1) % 8);
      chk($sformatf("R1 code %0d other source ignored", c), count, 2);
    end
  endtask

  task automatic testInvert();
    baseMode();
    @(negedge clk) modeR.clkInv = 1'b1;
    doTrig();
    srcPulse(0);
    chk("R2 falling edge clears", count, 0);
    @(negedge clk) srcs[0] = 1'b1;
    @(negedge clk);
    chk("R2 rising ignored", count, 0);
    srcs[0] = 1'b0;
    @(negedge clk);
    chk("R2 falling counts", count, 1);
  endtask

  task automatic testGate();
    baseMode();
    @(negedge clk) modeR.gateSel = 2'd2;
    doTrig();
    srcPulse(0);
    chk("R3 gate low blocks", count, 1);
    @(negedge clk) srcs[6] = 1'b1;
    srcPulse(0);
    chk("R3 gate high passes", count, 0);
    srcPulse(0);
    chk("R3 gated count", count, 1);
    @(negedge clk) begin modeR.gateSel = 2'd0; srcs[6] = 1'b0; end
    srcPulse(0);
    chk("R3 ungated count", count, 2);
  endtask

  task automatic testRc();
    baseMode();
    @(negedge clk) begin rcValue = 16'd3; modeR.rcTrigEn = 1'b1; end
    doTrig();
    pulses(0, 4);
    chk("R6 reaches compare", count, 3);
    srcPulse(0);
    chk("R6 compare resets", count, 0);
    srcPulse(0);
    chk("R6 counts after reset", count, 1);
    @(negedge clk) modeR.rcTrigEn = 1'b0;
    doTrig();
    pulses(0, 5);
    chk("R6 no reset when off", count, 4);
  endtask

  task automatic testCapture();
    baseMode();
    @(negedge clk) begin modeR.edgeA = EDGE_RISE; modeR.edgeB = EDGE_FALL; end
    doTrig();
    pulses(0, 5);
    capSet(1'b1);
    chk("R8 slot A value", capA, 4);
    chk("R8 slot A valid", capAValid, 1);
    doRead(1'b1, 1'b0, 1'b0);
    chk("R8 read clears A valid", capAValid, 0);
    pulses(0, 2);
    capSet(1'b0);
    chk("R8 slot B value", capB, 6);
    chk("R8 slot B valid", capBValid, 1);
    doRead(1'b0, 1'b1, 1'b0);
    srcPulse(0);
    capSet(1'b1);
    chk("R9 A reloads after B", capA, 7);
    doRead(1'b1, 1'b0, 1'b0);
    doTrig();
    capSet(1'b0);
    chk("R9 B blocked after trigger", capBValid, 0);
    chk("R9 B keeps old value", capB, 6);
    srcPulse(0);
    @(negedge clk) modeR.edgeA = EDGE_BOTH;
    pulses(0, 2);
    capSet(1'b1);
    chk("R8 either edge loads A", capA, 2);
    doRead(1'b1, 1'b0, 1'b0);
  endtask

  task automatic testOverrun();
    baseMode();
    @(negedge clk) begin modeR.edgeA = EDGE_RISE; modeR.edgeB = EDGE_FALL; end
    capSet(1'b0);
    doTrig();
    doRead(1'b1, 1'b1, 1'b1);
    capSet(1'b1);
    capSet(1'b0);
    chk("R12 no overrun on first loads", lovrFlag, 0);
    capSet(1'b1);
    chk("R12 overrun on unread A", lovrFlag, 1);
    doRead(1'b1, 1'b1, 1'b1);
    chk("R12 status read clears", lovrFlag, 0);
    capSet(1'b0);
    chk("R12 read slot no overrun", lovrFlag, 0);
    doRead(1'b1, 1'b1, 1'b0);
  endtask

  task automatic testStop();
    baseMode();
    @(negedge clk) begin
      modeR.edgeA = EDGE_RISE; modeR.edgeB = EDGE_FALL; modeR.stopOnB = 1'b1;
    end
    doTrig();
    pulses(0, 3);
    capSet(1'b1);
    capSet(1'b0);
    chk("R10 stopped after B", running, 0);
    doRead(1'b1, 1'b1, 1'b0);
    srcPulse(0);
    chk("R10 frozen while stopped", count, 2);
    doTrig();
    chk("R10 trigger restarts", running, 1);
    srcPulse(0);
    chk("R10 restart from zero", count, 0);
  endtask

  task automatic testDisable();
    baseMode();
    @(negedge clk) begin
      modeR.edgeA = EDGE_RISE; modeR.edgeB = EDGE_FALL; modeR.disOnB = 1'b1;
    end
    doTrig();
    pulses(0, 3);
    capSet(1'b1);
    capSet(1'b0);
    chk("R11 off after B", running, 0);
    doRead(1'b1, 1'b1, 1'b0);
    doTrig();
    chk("R11 trigger alone no restart", running, 0);
    srcPulse(0);
    chk("R11 frozen while off", count, 2);
    doEn();
    srcPulse(0);
    chk("R11 enable restarts from zero", count, 0);
  endtask

  task automatic testWave();
    baseMode();
    @(negedge clk) begin modeR.waveSel = 1'b1; modeR.edgeA = EDGE_RISE; end
    @(negedge clk);
    chk("R13 not running", running, 0);
    srcPulse(0);
    chk("R13 no counting", count, 0);
    capSet(1'b1);
    chk("R13 no capture", capAValid, 0);
    capSet(1'b0);
    baseMode();
  endtask

  task automatic testTop();
    baseMode();
    doTrig();
    srcPulse(0);
    chk("R7 start at zero", count, 0);
    fastCount(65534);
    srcPulse(0);
    chk("R7 reached top", count, 16'hFFFF);
    srcPulse(0);
    chk("R7 wrap to zero", count, 0);
    chk("R7 overflow flag", ovflFlag, 1);
    doRead(1'b0, 1'b0, 1'b1);
    chk("R7 status read clears", ovflFlag, 0);
    fastCount(65534);
    srcPulse(0);
    chk("R5 at top again", count, 16'hFFFF);
    doTrig();
    srcPulse(0);
    chk("R5 trigger at top clears", count, 0);
    chk("R5 no overflow on trigger", ovflFlag, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testEnable();
    testSelect();
    testInvert();
    testGate();
    testRc();
    testCapture();
    testOverrun();
    testStop();
    testDisable();
    testWave();
    testTop();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule